// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block links a single-cycle host request port to an external asynchronous SRAM-style device. When the controller is idle and the host pulses a request, the controller takes a snapshot of the address, the write data, the direction and the timing configuration. It then runs the memory access through three timed phases: setup, strobe and hold. After hold it inserts a turnaround gap. It signals completion with a one-clock done pulse. For reads, it returns the data it sampled at the end of the strobe phase.

A packed 32-bit timing word sets the length of every phase, with separate values for reads and writes. The same word also sets the turnaround length, the data lane width, whether chip select covers the whole access or only the strobe, and whether the memory's wait pin may stretch the strobe. A separate wait limit and wait polarity bound the stretch. A stretch that reaches the limit ends the access with a timeout indication.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, output enable and write enable are high (inactive), the data bus is not driven, and done and timeout are low.
- R2: The timing word field positions are: [1:0] lane width, [3:2] turnaround, [6:4] read hold, [12:7] read strobe, [16:13] read setup, [19:17] write hold, [25:20] write strobe, [29:26] write setup, [30] wait-stretch enable, [31] strobe-only select. A field value N gives N+1 clocks in its phase. Reads use the read fields and writes use the write fields.
- R3: Request, direction, address, write data, timing word, wait limit and wait polarity are sampled only on the clock that accepts a request from idle. Changes to them during an access, and requests raised while busy, have no effect on that access, and no second access starts.
- R4: Output enable is low only in the strobe phase of a read. Write enable is low only in the strobe phase of a write. With bit 31 clear, chip select is low from the first setup clock through the last hold clock.
- R5: With bit 31 set, chip select is low only during the strobe phase.
- R6: For a write, the data bus is driven from setup through hold. It is never driven for a read. The address output holds the accepted address for the whole access.
- R7: Read data is the memory input sampled on the final strobe clock. It is held until the next read capture.
- R8: After hold, the controller spends turnaround+1 clocks deselected before it can accept a new request. Done is high for exactly the first of those clocks.
- R9: With bit 30 clear, the wait input has no effect on the strobe length.
- R10: With bit 30 set, the wait input is active when it equals the wait polarity. If it is active on the last programmed strobe clock, the strobe extends by one clock for each active cycle, up to wait-limit extra clocks. If it is still active once that limit is used, the strobe ends and timeout is high together with done.
- R11: A lane width field of 0 uses only the low half of the data bus: the upper half of the driven write data and of the returned read data is zero. Any other value uses the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request pulse, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Access address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Captured read data |
| host_done | output | 1 | One-clock completion pulse |
| host_timeout | output | 1 | High with done when the wait stretch hit its limit |
| cfg_word | input | 32 | Packed timing word |
| wait_limit | input | WAIT_W | Maximum extra strobe clocks |
| wait_pol | input | 1 | Level of the wait input that counts as active |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_din | input | DATA_W | Data returned from memory |
| mem_dq_oe | output | 1 | Enables the data bus driver |
| mem_wait | input | 1 | Wait request from memory |

## Verification
The bench goes after phase-length off-by-one errors. A wrong count shows up as a strobe or hold that is one clock short or long against the expected cycle trace. The memory input changes on every strobe clock, so a capture one clock early or late returns the wrong word. Wait-stretch cases cover a stretch that ends on its own, a stretch that runs into its limit, a zero limit and a disabled stretch with wait held active. A design that ignored polarity, counted one cycle too many, or obeyed wait while disabled would show a strobe of the wrong length or a timeout in the wrong place. A busy-period test flips every host and configuration input during an access. A controller that sampled those inputs live, or accepted a second request, would show a changed address, changed timing or an extra select.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int CFG_W = 32;
    localparam int CNT_W = 6;

    // Field positions are fixed: software packs this word.
    typedef struct packed {
        logic       cs_on_pulse;  // [31]
        logic       xwait_en;     // [30]
        logic [3:0] wr_setup;     // [29:26]
        logic [5:0] wr_pulse;     // [25:20]
        logic [2:0] wr_hold;      // [19:17]
        logic [3:0] rd_setup;     // [16:13]
        logic [5:0] rd_pulse;     // [12:7]
        logic [2:0] rd_hold;      // [6:4]
        logic [1:0] gap;          // [3:2]
        logic [1:0] lanes;        // [1:0]
    } timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_GAP
    } phase_e;

    // Last count value of a phase (phase lasts value+1 clocks).
    function automatic logic [CNT_W-1:0] phase_len(timing_t t, phase_e p, logic wr);
        case (p)
            PH_SETUP: return wr ? CNT_W'(t.wr_setup) : CNT_W'(t.rd_setup);
            PH_PULSE: return wr ? CNT_W'(t.wr_pulse) : CNT_W'(t.rd_pulse);
            PH_HOLD:  return wr ? CNT_W'(t.wr_hold)  : CNT_W'(t.rd_hold);
            PH_GAP:   return CNT_W'(t.gap);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/asram_cfg_snap.sv
module asram_cfg_snap
    import asram_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [CFG_W-1:0]          cfg_word,
    input  logic [WAIT_W-1:0]         wait_limit,
    input  logic                      wait_pol,
    output timing_t                   cfg_q,
    output logic [WAIT_W-1:0]         wlim_q,
    output logic                      wpol_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wlim_q <= '0;
            wpol_q <= 1'b0;
        end else if (load) begin
            cfg_q  <= timing_t'(cfg_word);
            wlim_q <= wait_limit;
            wpol_q <= wait_pol;
        end
    end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              host_we,
    input  timing_t           cfg,
    input  logic [WAIT_W-1:0] wlim,
    input  logic              wpol,
    input  logic              mem_wait,
    output logic              accept,
    output phase_e            phase,
    output logic              wr,
    output logic              capture,
    output logic              done,
    output logic              timeout
);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len;
    logic [WAIT_W-1:0] xcnt_q;
    logic              wr_q;
    logic              tmo_seen_q;
    logic              done_q;
    logic              tmo_q;
    logic              at_end;
    logic              wait_act;
    logic              stretch;

    always_comb begin
        len      = phase_len(cfg, phase_q, wr_q);
        at_end   = (cnt_q == len);
        wait_act = cfg.xwait_en && (mem_wait == wpol);
        stretch  = (phase_q == PH_PULSE) && at_end && wait_act && (xcnt_q != wlim);
        accept   = (phase_q == PH_IDLE) && req;
        capture  = (phase_q == PH_PULSE) && at_end && !stretch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            xcnt_q     <= '0;
            wr_q       <= 1'b0;
            tmo_seen_q <= 1'b0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req) begin
                        phase_q    <= PH_SETUP;
                        cnt_q      <= '0;
                        xcnt_q     <= '0;
                        tmo_seen_q <= 1'b0;
                        wr_q       <= host_we;
                    end
                end
                PH_SETUP: begin
                    if (at_end) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (!at_end) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (stretch) begin
                        xcnt_q <= xcnt_q + 1'b1;
                    end else begin
                        phase_q    <= PH_HOLD;
                        cnt_q      <= '0;
                        tmo_seen_q <= wait_act;
                    end
                end
                PH_HOLD: begin
                    if (at_end) begin
                        phase_q <= PH_GAP;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                        tmo_q   <= tmo_seen_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (at_end) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign wr      = wr_q;
    assign done    = done_q;
    assign timeout = tmo_q;

    AST_WAIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE && at_end && !cfg.xwait_en) |=> (phase_q == PH_HOLD)); // R9
    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE) |-> (xcnt_q <= wlim)); // R10
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE || phase_q == PH_HOLD || phase_q == PH_GAP) |=> (phase_q != PH_SETUP)); // R3

endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv
    import asram_pkg::*;
(
    input  phase_e phase,
    input  logic   wr,
    input  logic   cs_on_pulse,
    output logic   cs_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_oe
);

    logic active;
    logic pulse;

    always_comb begin
        active = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
        pulse  = (phase == PH_PULSE);
        cs_n   = !(cs_on_pulse ? pulse : active);
        oe_n   = !(pulse && !wr);
        we_n   = !(pulse && wr);
        dq_oe  = active && wr;
    end

endmodule

// File: rtl/asram_xfer.sv
module asram_xfer #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [1:0]        lanes,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANE_W = DATA_W / 2;
    localparam int UPPER_W = DATA_W - LANE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] din_m;
    logic              narrow;

    always_comb begin
        narrow   = (lanes == 2'd0);
        mem_dout = narrow ? {{UPPER_W{1'b0}}, wdata_q[LANE_W-1:0]} : wdata_q;
        din_m    = narrow ? {{UPPER_W{1'b0}}, mem_din[LANE_W-1:0]} : mem_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (capture) begin
                rdata_q <= din_m;
            end
        end
    end

    assign mem_addr = addr_q;
    assign rdata    = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              host_timeout,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              wait_pol,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dq_oe,
    input  logic              mem_wait
);

    timing_t           cfg_q;
    logic [WAIT_W-1:0] wlim_q;
    logic              wpol_q;
    logic              accept;
    logic              capture;
    logic              wr;
    phase_e            phase;

    asram_cfg_snap #(.WAIT_W(WAIT_W)) i_snap (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .cfg_word   (cfg_word),
        .wait_limit (wait_limit),
        .wait_pol   (wait_pol),
        .cfg_q      (cfg_q),
        .wlim_q     (wlim_q),
        .wpol_q     (wpol_q)
    );

    asram_seq #(.WAIT_W(WAIT_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (host_req),
        .host_we  (host_we),
        .cfg      (cfg_q),
        .wlim     (wlim_q),
        .wpol     (wpol_q),
        .mem_wait (mem_wait),
        .accept   (accept),
        .phase    (phase),
        .wr       (wr),
        .capture  (capture),
        .done     (host_done),
        .timeout  (host_timeout)
    );

    asram_pin_drv i_pins (
        .phase       (phase),
        .wr          (wr),
        .cs_on_pulse (cfg_q.cs_on_pulse),
        .cs_n        (mem_cs_n),
        .oe_n        (mem_oe_n),
        .we_n        (mem_we_n),
        .dq_oe       (mem_dq_oe)
    );

    asram_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_xfer (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .lanes      (cfg_q.lanes),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_din    (mem_din),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .rdata      (host_rdata)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R4
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R4
    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe); // R6
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done); // R8
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        host_done |-> (mem_cs_n && !mem_dq_oe)); // R8
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        host_timeout |-> host_done); // R10

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              host_req;
    logic              host_we;
    logic [ADDR_W-1:0] host_addr;
    logic [DATA_W-1:0] host_wdata;
    logic [DATA_W-1:0] host_rdata;
    logic              host_done;
    logic              host_timeout;
    logic [31:0]       cfg_word;
    logic [WAIT_W-1:0] wait_limit;
    logic              wait_pol;
    logic              mem_cs_n;
    logic              mem_oe_n;
    logic              mem_we_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout;
    logic [DATA_W-1:0] mem_din;
    logic              mem_dq_oe;
    logic              mem_wait;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    asram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) i_asram_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .host_timeout(host_timeout), .cfg_word(cfg_word),
        .wait_limit(wait_limit), .wait_pol(wait_pol), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe),
        .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL [%s] %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mkcfg(int lanes, int gap, int rh, int rp, int rs,
                                          int wh, int wp, int ws, int xw, int cs);
        logic [31:0] c;
        c = '0;
        c[1:0]   = 2'(lanes);
        c[3:2]   = 2'(gap);
        c[6:4]   = 3'(rh);
        c[12:7]  = 6'(rp);
        c[16:13] = 4'(rs);
        c[19:17] = 3'(wh);
        c[25:20] = 6'(wp);
        c[29:26] = 4'(ws);
        c[30]    = 1'(xw);
        c[31]    = 1'(cs);
        return c;
    endfunction

    // Phase codes in the expected trace: 1 setup, 2 strobe, 3 hold, 4 gap.
    task automatic run_access(input string tag, input bit wr, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] wd, input logic [31:0] cfg,
                              input int wl, input bit wp, input int k_wait,
                              input logic [DATA_W-1:0] din_base, input bit poke);
        int su, st, ho, ta, ext, si;
        bit tmo, xw, sel, narrow, gap_first;
        int phq[$];
        logic [DATA_W-1:0] last_din, exp_val;
        xw     = cfg[30];
        sel    = cfg[31];
        narrow = (cfg[1:0] == 2'd0);
        ta     = int'(cfg[3:2]);
        su = wr ? int'(cfg[29:26]) : int'(cfg[16:13]);
        st = wr ? int'(cfg[25:20]) : int'(cfg[12:7]);
        ho = wr ? int'(cfg[19:17]) : int'(cfg[6:4]);
        if (!xw) begin
            ext = 0;
            tmo = 1'b0;
        end else begin
            ext = (k_wait > st) ? k_wait - st : 0;
            if (ext > wl) ext = wl;
            tmo = (k_wait > st + wl);
        end
        for (int i = 0; i < su + 1; i++) phq.push_back(1);
        for (int i = 0; i < st + 1 + ext; i++) phq.push_back(2);
        for (int i = 0; i < ho + 1; i++) phq.push_back(3);
        for (int i = 0; i < ta + 1; i++) phq.push_back(4);

        cfg_word   = cfg;
        wait_limit = WAIT_W'(wl);
        wait_pol   = wp;
        host_we    = wr;
        host_addr  = a;
        host_wdata = wd;
        host_req   = 1'b1;
        @(negedge clk);
        host_req  = poke;
        si        = 0;
        gap_first = 1'b1;
        last_din  = '0;
        foreach (phq[c]) begin
            int ph;
            ph = phq[c];
            if (poke) begin
                host_addr  = ~a;
                host_wdata = ~wd;
                host_we    = ~wr;
                cfg_word   = ~cfg;
                wait_limit = ~WAIT_W'(wl);
                wait_pol   = ~wp;
            end
            if (ph == 2) begin
                mem_wait = (si < k_wait) ? wp : ~wp;
                mem_din  = din_base + DATA_W'(si);
                last_din = mem_din;
                si++;
            end else begin
                mem_wait = ~wp;
                mem_din  = '0;
            end
            chk({tag, " R4"}, "cs_n", 32'(mem_cs_n),
                32'(sel ? !(ph == 2) : !(ph >= 1 && ph <= 3)));
            chk({tag, " R4"}, "oe_n", 32'(mem_oe_n), 32'(!(ph == 2 && !wr)));
            chk({tag, " R4"}, "we_n", 32'(mem_we_n), 32'(!(ph == 2 && wr)));
            chk({tag, " R6"}, "dq_oe", 32'(mem_dq_oe), 32'(wr && ph >= 1 && ph <= 3));
            chk({tag, " R8"}, "done", 32'(host_done), 32'(ph == 4 && gap_first));
            chk({tag, " R10"}, "timeout", 32'(host_timeout), 32'(ph == 4 && gap_first && tmo));
            if (ph != 4) chk({tag, " R6"}, "addr", 32'(mem_addr), 32'(a));
            if (wr && ph != 4) begin
                exp_val = narrow ? {8'h00, wd[7:0]} : wd;
                chk({tag, " R11"}, "dout", 32'(mem_dout), 32'(exp_val));
            end
            if (!wr && ph == 4 && gap_first) begin
                exp_val = narrow ? {8'h00, last_din[7:0]} : last_din;
                chk({tag, " R7"}, "rdata", 32'(host_rdata), 32'(exp_val));
            end
            if (ph == 4) gap_first = 1'b0;
            @(negedge clk);
        end
        host_req = 1'b0;
        mem_wait = ~wp;
        @(negedge clk);
        chk({tag, " R3"}, "idle cs_n", 32'(mem_cs_n), 32'd1);
        chk({tag, " R3"}, "idle dq_oe", 32'(mem_dq_oe), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        host_req   = 1'b0;
        host_we    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        cfg_word   = '0;
        wait_limit = '0;
        wait_pol   = 1'b0;
        mem_din    = '0;
        mem_wait   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "cs_n in reset", 32'(mem_cs_n), 32'd1);
        chk("R1", "oe_n in reset", 32'(mem_oe_n), 32'd1);
        chk("R1", "we_n in reset", 32'(mem_we_n), 32'd1);
        chk("R1", "dq_oe in reset", 32'(mem_dq_oe), 32'd0);
        chk("R1", "done in reset", 32'(host_done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "cs_n after reset", 32'(mem_cs_n), 32'd1);
        chk("R1", "timeout after reset", 32'(host_timeout), 32'd0);

        // Read, 4-clock strobe, single-clock setup and hold.
        run_access("R2 read", 1'b0, 20'h12345, '0, mkcfg(1,0,0,3,0,0,0,0,0,0), 0, 1'b0, 0, 16'hA500, 1'b0);
        // Write with distinct write fields and a 2-clock gap.
        run_access("R2 write", 1'b1, 20'h0ABCD, 16'hBEEF, mkcfg(1,1,2,1,3,5,4,2,0,0), 0, 1'b0, 0, '0, 1'b0);
        // Read with the same word: read fields now apply.
        run_access("R2 R8 read", 1'b0, 20'h00F0F, '0, mkcfg(1,1,2,1,3,5,4,2,0,0), 0, 1'b0, 0, 16'h3C00, 1'b0);
        // Strobe-only select, narrow lane, read then write.
        run_access("R5 R11 read", 1'b0, 20'h55555, '0, mkcfg(0,2,1,2,1,0,0,0,0,1), 0, 1'b0, 0, 16'hC3F0, 1'b0);
        run_access("R5 R11 write", 1'b1, 20'hAAAAA, 16'h9A7E, mkcfg(0,0,0,0,0,1,2,1,0,1), 0, 1'b0, 0, '0, 1'b0);
        // Wait held active with stretch disabled.
        run_access("R9", 1'b0, 20'h00111, '0, mkcfg(1,0,0,2,0,0,0,0,0,0), 4, 1'b1, 100, 16'h7700, 1'b0);
        // Stretch that ends before the limit.
        run_access("R10 stretch", 1'b0, 20'h00222, '0, mkcfg(1,0,1,2,1,0,0,0,1,0), 5, 1'b1, 4, 16'h1200, 1'b0);
        // Stretch that hits the limit, active-low wait.
        run_access("R10 limit", 1'b0, 20'h00333, '0, mkcfg(1,1,0,1,0,0,0,0,1,0), 3, 1'b0, 100, 16'h4400, 1'b0);
        // Zero limit on a write: immediate timeout.
        run_access("R10 zero", 1'b1, 20'h00444, 16'h600D, mkcfg(1,0,0,0,0,1,2,0,1,0), 0, 1'b1, 100, '0, 1'b0);
        // Busy period: every input flipped, requests raised.
        run_access("R3 busy", 1'b1, 20'h0F00F, 16'h5AA5, mkcfg(1,1,1,1,1,2,3,1,0,0), 2, 1'b1, 0, '0, 1'b1);
        // Full width with lane value other than 1.
        run_access("R11 R7 wide", 1'b0, 20'h7E7E7, '0, mkcfg(3,3,0,0,2,0,0,0,0,0), 0, 1'b0, 0, 16'hF1E0, 1'b0);
        // Back-to-back reads with the longest gap.
        run_access("R8 gap", 1'b0, 20'h01234, '0, mkcfg(1,3,0,5,0,0,0,0,0,0), 0, 1'b0, 0, 16'h0880, 1'b0);
        run_access("R8 gap2", 1'b0, 20'h04321, '0, mkcfg(1,3,7,0,15,0,0,0,0,0), 0, 1'b0, 0, 16'h0990, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule